// File: doc/BRIEF.md
# Register Write-Protect Unlock Sequencer

This block sits on a peripheral's register write bus and protects its configuration registers with a single write-protect flag. While the flag is set, writes to the protected registers are dropped. Each dropped write sets a sticky error bit, which software clears by writing a one to it.

The flag cannot be changed by a plain write to the control register. Software must first write three keys in a fixed order across two unlock addresses. The completed sequence grants one pass, which is used by the very next bus write. If that write targets the control register, it loads the flag from its data bit. If it targets anything else, the pass is lost. A write that breaks the key order sends the tracker back to its start. Reads leave the tracker alone.

The bus has no back-pressure. `bus_wr` and `bus_rd` work as valid strobes that are always accepted in the cycle they are high. `reg_we` is the qualified write enable for the protected registers. It is combinational from the bus in that same cycle. The flag, the error bit and the unlock state update on the next clock edge.

Top module: `wp_unlock_guard`

## Requirements
- R1: After reset, `wp_flag` equals `RESET_PROTECT` (default 1), `wp_err` is 0, `unlock_armed` is 0 and `reg_we` is 0 with no bus activity.
- R2: Three writes arm the unlock: 0x7123 to offset 0x18, then 0x812A to offset 0x1C, then 0xBEE1 to offset 0x18. `unlock_armed` goes high on the edge that takes the third write.
- R3: A write that does not match the next expected key, by address or by data, returns the tracker to its start. A later correct third key then does not arm.
- R4: Read strobes between key writes do not disturb sequence progress.
- R5: While `wp_flag` is 1 and the unlock is not armed, a write to any forwarded offset gives `reg_we` = 0. This includes control at offset 0x00. Forwarded offsets are all offsets except 0x18, 0x1C and 0x2C.
- R6: A write dropped under R5 sets `wp_err` on the following edge. `wp_err` then stays 1 until it is cleared as in R7.
- R7: A write to status offset 0x2C with data bit 1 set clears `wp_err`. With data bit 1 clear, `wp_err` is unchanged.
- R8: While armed, the next write drops the arm. If that write targets control offset 0x00, `reg_we` is 1 and `wp_flag` loads data bit 1.
- R9: With `wp_flag` at 0, forwarded writes give `reg_we` = 1. A control write without the arm leaves `wp_flag` unchanged.
- R10: Writes to 0x18, 0x1C and 0x2C never raise `reg_we` and never set `wp_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, always accepted |
| bus_rd | input | 1 | Read strobe, has no effect on state |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | DW | Write data |
| reg_we | output | 1 | Qualified write enable to protected registers |
| wp_flag | output | 1 | Write-protect flag (control bit 1) |
| wp_err | output | 1 | Sticky write-protect error (status bit 1) |
| unlock_armed | output | 1 | One-shot pass granted by the key sequence |

## Verification
The bench builds the block with its defaults: 8-bit offsets, 32-bit data and protection on from reset. With protection on from reset, blocked writes and the error flag can be reached without first running an unlock. The 32-bit data path lets a key that is wrong by only its low bits break the sequence. The bench drives blocked writes, error clearing, broken and read-interleaved key sequences, lost passes and re-protection through a queue of expected results.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_KEY1 = 2'd1,
    SQ_KEY2 = 2'd2,
    SQ_ARM  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/wpg_seq.sv
module wpg_seq
  import wpg_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] UNL_A = 8'h18,
  parameter logic [AW-1:0] UNL_B = 8'h1C,
  parameter logic [DW-1:0] KEY1 = 32'h7123,
  parameter logic [DW-1:0] KEY2 = 32'h812A,
  parameter logic [DW-1:0] KEY3 = 32'hBEE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          armed
);
  seq_state_t st_q, st_d;

  logic hit1, hit2, hit3;
  assign hit1 = wr && addr == UNL_A && wdata == KEY1;
  assign hit2 = wr && addr == UNL_B && wdata == KEY2;
  assign hit3 = wr && addr == UNL_A && wdata == KEY3;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE: if (hit1) st_d = SQ_KEY1;
      SQ_KEY1: if (hit2) st_d = SQ_KEY2; else if (wr) st_d = SQ_IDLE;
      SQ_KEY2: if (hit3) st_d = SQ_ARM;  else if (wr) st_d = SQ_IDLE;
      SQ_ARM:  if (wr)   st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;

  assign armed = (st_q == SQ_ARM);

  // R4: cycles without a write leave progress untouched
  p_reads_inert_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(st_q));
  // R8: the pass serves a single write only
  p_arm_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && wr |=> !armed);
  // R2: arming only follows the third key
  p_arm_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(hit3));
endmodule

// File: rtl/wpg_gate.sv
module wpg_gate #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] CTRL_A = 8'h00,
  parameter logic [AW-1:0] STAT_A = 8'h2C,
  parameter logic [AW-1:0] UNL_A = 8'h18,
  parameter logic [AW-1:0] UNL_B = 8'h1C,
  parameter int WP_BIT = 1,
  parameter int ERR_BIT = 1,
  parameter bit RESET_PROTECT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          armed_i,
  output logic          reg_we,
  output logic          wp_q,
  output logic          err_q
);
  logic is_ctl, is_st, is_unl, fwd, ctl_load, blocked;

  assign is_ctl   = (addr == CTRL_A);
  assign is_st    = (addr == STAT_A);
  assign is_unl   = (addr == UNL_A) || (addr == UNL_B);
  assign fwd      = wr && !is_unl && !is_st;
  assign ctl_load = wr && is_ctl && armed_i;
  assign blocked  = fwd && wp_q && !ctl_load;
  assign reg_we   = fwd && !blocked;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        wp_q <= RESET_PROTECT;
    else if (ctl_load) wp_q <= wdata[WP_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                           err_q <= 1'b0;
    else if (blocked)                     err_q <= 1'b1;
    else if (wr && is_st && wdata[ERR_BIT]) err_q <= 1'b0;

  // R5: no forwarded write while locked
  p_locked_no_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && wp_q |-> armed_i);
  // R6: a locked plain write leaves the error raised
  p_err_on_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr && wp_q && !armed_i && !is_unl && !is_st |=> err_q);
  // R6: error is sticky until a status write
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !(wr && is_st) |=> err_q);
  // R8: the flag moves only through an armed pass
  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_i |=> $stable(wp_q));
endmodule

// File: rtl/wp_unlock_guard.sv
module wp_unlock_guard #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] CTRL_A = 8'h00,
  parameter logic [AW-1:0] STAT_A = 8'h2C,
  parameter logic [AW-1:0] UNL_A = 8'h18,
  parameter logic [AW-1:0] UNL_B = 8'h1C,
  parameter logic [DW-1:0] KEY1 = 32'h7123,
  parameter logic [DW-1:0] KEY2 = 32'h812A,
  parameter logic [DW-1:0] KEY3 = 32'hBEE1,
  parameter bit RESET_PROTECT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          reg_we,
  output logic          wp_flag,
  output logic          wp_err,
  output logic          unlock_armed
);
  localparam int WP_BIT  = 1;
  localparam int ERR_BIT = 1;

  logic armed;
  logic rd_unused;
  assign rd_unused = bus_rd;

  wpg_seq #(
    .AW(AW), .DW(DW), .UNL_A(UNL_A), .UNL_B(UNL_B),
    .KEY1(KEY1), .KEY2(KEY2), .KEY3(KEY3)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .armed(armed)
  );

  wpg_gate #(
    .AW(AW), .DW(DW), .CTRL_A(CTRL_A), .STAT_A(STAT_A),
    .UNL_A(UNL_A), .UNL_B(UNL_B), .WP_BIT(WP_BIT), .ERR_BIT(ERR_BIT),
    .RESET_PROTECT(RESET_PROTECT)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .armed_i(armed), .reg_we(reg_we),
    .wp_q(wp_flag), .err_q(wp_err)
  );

  assign unlock_armed = armed;

  // R10: unlock and status writes are never forwarded
  p_side_no_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (bus_addr == UNL_A || bus_addr == UNL_B || bus_addr == STAT_A) |-> !reg_we);
  // R1: quiet bus forwards nothing
  p_idle_no_we_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |-> !reg_we);
endmodule

// File: tb/sim_wp_unlock_guard.sv
module sim_wp_unlock_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic reg_we, wp_flag, wp_err, unlock_armed;

  always #2 clk = ~clk;

  wp_unlock_guard u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .reg_we(reg_we),
    .wp_flag(wp_flag), .wp_err(wp_err), .unlock_armed(unlock_armed)
  );

  typedef struct {
    bit we; bit f; bit e; bit a; bit ph; string tag;
  } item_t;
  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, string what, bit act, bit exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act %0b exp %0b", tag, what, act, exp);
    end
  endtask

  // driver: one bus cycle, expected result pushed to the scoreboard
  task automatic drv(bit w, bit r, logic [7:0] a, logic [31:0] d,
                     bit we, bit f, bit e, bit arm, string tag);
    item_t it;
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    it.we = we; it.f = f; it.e = e; it.a = arm; it.ph = 0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  // monitor: we checked in the drive cycle, state after the next edge
  initial forever begin
    @(negedge clk); #1;
    if (q.size() > 0 && q[0].ph) begin
      chk(q[0].tag, "wp_flag", wp_flag, q[0].f);
      chk(q[0].tag, "wp_err", wp_err, q[0].e);
      chk(q[0].tag, "unlock_armed", unlock_armed, q[0].a);
      void'(q.pop_front());
    end
    if (q.size() > 0 && !q[0].ph) begin
      chk(q[0].tag, "reg_we", reg_we, q[0].we);
      q[0].ph = 1;
    end
  end

  task automatic keys(bit f, bit e, string tag);
    drv(1,0,8'h18,32'h7123, 0,f,e,0,tag);
    drv(1,0,8'h1C,32'h812A, 0,f,e,0,tag);
    drv(1,0,8'h18,32'hBEE1, 0,f,e,1,tag);
  endtask

  initial begin
    #(200000*4);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act hung exp done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "wp_flag", wp_flag, 1'b1);
    chk("R1", "wp_err", wp_err, 1'b0);
    chk("R1", "unlock_armed", unlock_armed, 1'b0);
    chk("R1", "reg_we", reg_we, 1'b0);
    // R5 R6: locked plain and control writes dropped, error sticky
    drv(1,0,8'h04,32'h1, 0,1,1,0,"R5");
    idle();
    drv(1,0,8'h00,32'h0, 0,1,1,0,"R6");
    // R7 R10: status write with bit1 clear keeps error, set clears
    drv(1,0,8'h2C,32'h0, 0,1,1,0,"R7");
    drv(1,0,8'h2C,32'h2, 0,1,0,0,"R7");
    // R3: wrong data in the middle breaks the sequence
    drv(1,0,8'h18,32'h7123, 0,1,0,0,"R10");
    drv(1,0,8'h1C,32'h812B, 0,1,0,0,"R3");
    drv(1,0,8'h18,32'hBEE1, 0,1,0,0,"R3");
    drv(1,0,8'h00,32'h0, 0,1,1,0,"R3");
    drv(1,0,8'h2C,32'hFFFFFFFF, 0,1,0,0,"R7");
    // R2 R4: reads between keys do not disturb progress
    drv(1,0,8'h18,32'h7123, 0,1,0,0,"R4");
    drv(0,1,8'h18,32'h0, 0,1,0,0,"R4");
    drv(1,0,8'h1C,32'h812A, 0,1,0,0,"R4");
    drv(0,1,8'h00,32'h0, 0,1,0,0,"R4");
    drv(1,0,8'h18,32'hBEE1, 0,1,0,1,"R2");
    // R8: armed control write clears protection
    drv(1,0,8'h00,32'h0, 1,0,0,0,"R8");
    // R9: unprotected writes pass; unarmed control cannot set flag
    drv(1,0,8'h04,32'h5, 1,0,0,0,"R9");
    drv(1,0,8'h00,32'h2, 1,0,0,0,"R9");
    // R8: pass lost on a non-control write
    keys(0,0,"R2");
    drv(1,0,8'h08,32'h2, 1,0,0,0,"R8");
    drv(1,0,8'h00,32'h2, 1,0,0,0,"R8");
    // R8: re-protect through an armed control write
    keys(0,0,"R2");
    drv(1,0,8'h00,32'h2, 1,1,0,0,"R8");
    drv(1,0,8'h0C,32'h1, 0,1,1,0,"R5");
    drv(1,0,8'h2C,32'h2, 0,1,0,0,"R7");
    // R3: wrong address breaks the sequence
    drv(1,0,8'h18,32'h7123, 0,1,0,0,"R3");
    drv(1,0,8'h10,32'h812A, 0,1,1,0,"R3");
    drv(1,0,8'h18,32'hBEE1, 0,1,1,0,"R3");
    idle();
    idle();
    idle();
    chk("R3", "queue_empty", q.size() == 0, 1'b1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule